// File: doc/BRIEF.md
# Sleep Entry and Timed Auto-Wakeup Controller

This block sits inside a clock management unit. It gates the clock to the core while the core sleeps and decides when the core resumes. When the core asks to sleep, the block drops its clock-enable output on the next cycle. It then waits on the clock that drives it, which is the newly selected source clock after a source switch. When the wait is over, it raises the enable again and gives a one-cycle resume pulse. No interrupt is needed for this. Because of this, a change of clock source can finish across the sleep stall, and the core restarts only once the new source has had time to settle.

The wait length is an 8-bit count. Each count unit is one prescale period of 256 source-clock cycles, so the core sleeps for count × 256 cycles. A count of zero behaves like a count of one. A mode input selects another behaviour: the timer is not used, and the core wakes only on an interrupt. The count and the mode are captured when sleep is entered.

Top module: `sleep_wake_timer`

## Requirements
- R1: After reset, `clk_en` is 1 and `resume` is 0.
- R2: A `sleep_req` sampled high while `clk_en` is 1 makes `clk_en` 0 from the next cycle.
- R3: With `wake_on_irq` = 0 captured and a count N from 1 to 255 captured, `clk_en` stays 0 for exactly N × 256 cycles.
- R4: A captured count of 0 gives a wait of exactly 256 cycles.
- R5: `resume` is a one-cycle pulse. It is high in exactly the cycle where `clk_en` returns to 1, and never at any other time.
- R6: With `wake_on_irq` = 1 captured, the timer has no effect. The block stays asleep until `irq` is sampled high, and in the next cycle `clk_en` returns to 1 with `resume` high.
- R7: With `wake_on_irq` = 0 captured, `irq` has no effect on the wait length.
- R8: A `sleep_req` that arrives while a wait is in progress is ignored, and the wait length does not change.
- R9: `wait_count` and `wake_on_irq` are sampled only in the cycle where sleep is entered. Changing them during the wait has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock (the newly selected clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter sleep |
| wait_count | input | 8 | Wait length in units of 256 cycles; 0 behaves like 1 |
| wake_on_irq | input | 1 | 0: timed wakeup, 1: wake only on interrupt |
| irq | input | 1 | Interrupt line |
| clk_en | output | 1 | Core clock enable; 0 while asleep |
| resume | output | 1 | One-cycle pulse when the core restarts |

## Verification
The timed path is run with counts 3, 1, 0 and 255. These tell a correct multiply-by-256 apart from off-by-one errors at the prescale wrap, and they show the zero-count special case. They also cover the full top of the count range. A wait that receives interrupt pulses, and a wait that receives a second sleep request, must have exactly the same length as an undisturbed wait. This shows that the timed mode ignores both inputs. A wait in which the count and mode inputs are changed shows that they are captured at entry. An interrupt-mode wait stays asleep well past any timer period and then wakes exactly one cycle after the interrupt.

// File: rtl/sleep_wake_timer.sv
`timescale 1ns/1ps
module sleep_wake_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [CNT_W-1:0] wait_count,
  input  logic             wake_on_irq,
  input  logic             irq,
  output logic             clk_en,
  output logic             resume
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic             asleep_q;
  logic             mode_q;
  logic [CNT_W-1:0] rem_q;
  logic [PRE_W-1:0] pre_q;
  logic             resume_q;

  logic pre_wrap, last_unit, timer_done, irq_done, wake, enter;

  assign pre_wrap   = (pre_q == PRE_LAST);
  assign last_unit  = (rem_q[CNT_W-1:1] == '0);
  assign timer_done = asleep_q & ~mode_q & pre_wrap & last_unit;
  assign irq_done   = asleep_q & mode_q & irq;
  assign wake       = timer_done | irq_done;
  assign enter      = ~asleep_q & sleep_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      mode_q   <= 1'b0;
      rem_q    <= '0;
      pre_q    <= '0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= wake;
      if (enter) begin
        asleep_q <= 1'b1;
        mode_q   <= wake_on_irq;
        rem_q    <= wait_count;
        pre_q    <= '0;
      end else if (wake) begin
        asleep_q <= 1'b0;
      end else if (asleep_q && !mode_q) begin
        pre_q <= pre_q + 1'b1;
        if (pre_wrap) rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign clk_en = ~asleep_q;
  assign resume = resume_q;
endmodule

module sleep_wake_timer_chk #(
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic             irq,
  input logic             clk_en,
  input logic             resume,
  input logic             mode_q,
  input logic [PRE_W-1:0] pre_q
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && sleep_req |=> !clk_en);

  p_rise_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> resume);

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  p_pulse_after_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> clk_en && !$past(clk_en));

  p_irq_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en && mode_q && irq |=> resume);

  p_irq_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en && !mode_q && pre_q != PRE_LAST |=> !resume && !clk_en);

  p_sleep_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en && sleep_req && !mode_q && pre_q != PRE_LAST |=> !clk_en);
endmodule

bind sleep_wake_timer sleep_wake_timer_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq(irq),
  .clk_en(clk_en), .resume(resume), .mode_q(mode_q), .pre_q(pre_q)
);

// File: tb/test_sleep_wake_timer.sv
`timescale 1ns/1ps
module test_sleep_wake_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic [7:0] wait_count = '0;
  logic       wake_on_irq = 1'b0;
  logic       irq = 1'b0;
  logic       clk_en, resume;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sleep_wake_timer i_sleep_wake_timer (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wait_count(wait_count),
    .wake_on_irq(wake_on_irq), .irq(irq), .clk_en(clk_en), .resume(resume)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Pulses sleep_req for one cycle, then counts the low cycles of clk_en.
  // Each cycle may pulse irq or sleep_req, and may change the inputs at cycle 100.
  task automatic timed_wait(input logic [7:0] n, input bit poke_irq, input bit poke_sleep,
                            input bit change_inputs, output int low);
    wake_on_irq = 1'b0;
    wait_count  = n;
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
    check("R2", clk_en, 0);
    low = 1;
    for (int i = 0; i < 70000; i++) begin
      irq       = poke_irq   && (low % 7 == 3);
      sleep_req = poke_sleep && (low % 5 == 1);
      if (change_inputs && low == 100) begin
        wait_count  = 8'd200;
        wake_on_irq = 1'b1;
      end
      @(negedge clk);
      if (clk_en) break;
      low++;
    end
    irq = 1'b0;
    sleep_req = 1'b0;
    check("R5 resume with clk_en rise", resume, 1);
    @(negedge clk);
    check("R5 single pulse", resume, 0);
    wake_on_irq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 clk_en", clk_en, 1);
    check("R1 resume", resume, 0);
  endtask

  task automatic t_timed(input logic [7:0] n, input string req);
    int low;
    timed_wait(n, 1'b0, 1'b0, 1'b0, low);
    check(req, low, (n == 0 ? 1 : n) * 256);
  endtask

  task automatic t_irq_ignored();
    int low;
    timed_wait(8'd2, 1'b1, 1'b0, 1'b0, low);
    check("R7", low, 512);
  endtask

  task automatic t_sleep_ignored();
    int low;
    timed_wait(8'd2, 1'b0, 1'b1, 1'b0, low);
    check("R8", low, 512);
  endtask

  task automatic t_capture();
    int low;
    timed_wait(8'd2, 1'b0, 1'b0, 1'b1, low);
    check("R9", low, 512);
  endtask

  task automatic t_irq_mode();
    int en_seen = 0;
    int pulse_seen = 0;
    wake_on_irq = 1'b1;
    wait_count  = 8'd1;
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
    check("R2 irq mode", clk_en, 0);
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      en_seen    += clk_en;
      pulse_seen += resume;
    end
    check("R6 no timer wake", en_seen, 0);
    check("R6 no early pulse", pulse_seen, 0);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    check("R6 clk_en after irq", clk_en, 1);
    check("R6 resume after irq", resume, 1);
    @(negedge clk);
    check("R5 single pulse irq", resume, 0);
    wake_on_irq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #700us;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timed(8'd3,   "R3 count 3");
    t_timed(8'd1,   "R3 count 1");
    t_timed(8'd0,   "R4 count 0");
    t_irq_ignored();
    t_sleep_ignored();
    t_capture();
    t_irq_mode();
    t_timed(8'd255, "R3 count 255");
    summary();
  end
endmodule